// File: doc/BRIEF.md
# PMBus Packet Error Code Checker

This block sits behind an I2C byte engine on the slave side of a PMBus link and protects every transaction with a CRC-8 packet error code. The byte engine reports bus events as single-cycle markers: a START, a repeated START, a STOP, and one strobe per byte together with the byte value and a flag that says whether the slave or the master drove that byte. The checker runs the CRC over every byte of the message. This includes the address bytes and the write address and command that come before a repeated-start read.

On a write, the last byte the master sends must be the packet error code. At STOP the block either accepts the command with a one-cycle pulse or refuses it with a one-cycle error pulse. A write with no trailing code is refused the same way. On a read, the block continuously presents the CRC of everything seen so far. After the slave's last data byte, that value is exactly the byte the slave must append. Command decoding belongs to the consumer of the accept pulse.

Top module: `pmbus_pec_check`

## Requirements
- R1: The CRC uses the polynomial x^8 + x^2 + x + 1 (0x07), processes each byte MSB first, and starts from 0x00. `pec_byte` equals the CRC of all bytes seen since the last START, one cycle after each byte strobe.
- R2: A START sets the running CRC to 0x00, so `pec_byte` reads 0x00 in the cycle after a START that carries no byte.
- R3: A repeated START leaves the running CRC unchanged. The CRC of a read therefore includes the write address, the command and the read address.
- R4: Bytes driven by the slave (`byte_dir` = 1) are included in the CRC. After the last slave data byte, `pec_byte` is the code to append. After the appended code has also been counted, `pec_byte` reads 0x00.
- R5: A write frame is accepted when its last master byte brings the CRC to 0x00 and at least two bytes preceded that byte. Acceptance is a one-cycle `cmd_accept` pulse in the cycle after the STOP.
- R6: When the code does not match, the STOP produces a one-cycle `pec_err` pulse in the cycle after it and no `cmd_accept`.
- R7: A write without a trailing code is refused with `pec_err` at STOP. This covers an address-only frame, a frame whose residue is not zero, and a frame where a zero residue follows fewer than two bytes.
- R8: `cmd_accept` and `pec_err` are never high together, and each lasts one cycle. A STOP ends a frame silently, with neither pulse, in two cases: the frame contained any slave-driven byte, or it carried no bytes.
- R9: A byte strobe in the same cycle as a STOP is counted before the STOP is judged. A byte strobe in the same cycle as a START is counted as the first byte of the new frame.
- R10: While reset is held and after it is released, `cmd_accept` and `pec_err` are 0 and `pec_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_start | input | 1 | START condition seen (one cycle) |
| frm_rstart | input | 1 | Repeated START seen (one cycle) |
| frm_stop | input | 1 | STOP condition seen (one cycle) |
| byte_vld | input | 1 | A whole byte has passed on the bus |
| byte_dir | input | 1 | 1: slave drove the byte, 0: master drove it |
| byte_data | input | 8 | Byte value |
| cmd_accept | output | 1 | Write frame accepted (one-cycle pulse) |
| pec_err | output | 1 | Write frame refused (one-cycle pulse) |
| pec_byte | output | 8 | Running CRC, the code to append on reads |

## Verification
Two pairs of events can land in the same cycle. The final code byte can arrive with the STOP, and the first address byte can arrive with the START. The bench drives both pairs as single combined cycles. For a byte arriving with the STOP, it expects the accept pulse to reflect the byte that arrived in that cycle. For a byte arriving with the START, it expects `pec_byte` to equal the CRC of that byte alone, even though the previous frame left a non-zero CRC behind. Separate frames with the same content, where the events fall in distinct cycles, give the reference the combined cases must match.

// File: rtl/pec_pkg.sv
package pec_pkg;
    localparam int PEC_W     = 8;
    localparam int PEC_CNT_W = 4;
    localparam logic [PEC_W-1:0] PEC_POLY = 8'h07;
    localparam logic [PEC_W-1:0] PEC_INIT = 8'h00;
endpackage

// File: rtl/pec_crc_step.sv
// One byte through the CRC, MSB first, as an unrolled chain of shift stages.
module pec_crc_step #(
    parameter int              W    = pec_pkg::PEC_W,
    parameter logic [W-1:0]    POLY = pec_pkg::PEC_POLY
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] stage [0:W];

    assign stage[0] = crc_in;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic fb;
        assign fb           = stage[g][W-1] ^ data_in[W-1-g];
        assign stage[g+1]   = {stage[g][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = stage[W];
endmodule

// File: rtl/pec_frame_seq.sv
// Frame sequencer: tracks CRC, byte count and residue, judges the frame at STOP.
module pec_frame_seq #(
    parameter int           W       = pec_pkg::PEC_W,
    parameter int           CNT_W   = pec_pkg::PEC_CNT_W,
    parameter logic [W-1:0] INIT    = pec_pkg::PEC_INIT,
    parameter int           MIN_HDR = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frm_start,
    input  logic         frm_rstart,
    input  logic         frm_stop,
    input  logic         byte_vld,
    input  logic         byte_dir,
    input  logic [W-1:0] crc_next,
    output logic [W-1:0] crc_base,
    output logic [W-1:0] crc_cur,
    output logic         accept,
    output logic         err
);
    localparam logic [CNT_W-1:0] HDR_MIN = CNT_W'(MIN_HDR);

    typedef struct packed {
        logic [W-1:0]     crc;
        logic [CNT_W-1:0] cnt;
        logic             ok;
        logic             rd;
        logic             busy;
        logic             accept;
        logic             err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        crc_base = frm_start ? INIT : s_q.crc;
    end

    always_comb begin
        s_d        = s_q;
        s_d.accept = 1'b0;
        s_d.err    = 1'b0;
        if (frm_start) begin
            s_d.crc  = INIT;
            s_d.cnt  = '0;
            s_d.ok   = 1'b0;
            s_d.rd   = 1'b0;
            s_d.busy = 1'b1;
        end
        if (frm_rstart) begin
            s_d.ok = 1'b0;
        end
        if (byte_vld) begin
            s_d.ok = !byte_dir && (crc_next == '0) && (s_d.cnt >= HDR_MIN);
            if (byte_dir) begin
                s_d.rd = 1'b1;
            end
            if (s_d.cnt != '1) begin
                s_d.cnt = s_d.cnt + 1'b1;
            end
            s_d.crc = crc_next;
        end
        if (frm_stop) begin
            if (s_d.busy && (s_d.cnt != '0) && !s_d.rd) begin
                s_d.accept = s_d.ok;
                s_d.err    = !s_d.ok;
            end
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.crc <= INIT;
        end else begin
            s_q     <= s_d;
        end
    end

    assign crc_cur = s_q.crc;
    assign accept  = s_q.accept;
    assign err     = s_q.err;

    assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.accept && s_q.err));

    assert_accept_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.accept |-> $past(frm_stop));

    assert_err_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |-> $past(frm_stop));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && !byte_vld) |=> (s_q.crc == INIT));

    assert_rstart_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_rstart && !frm_start && !byte_vld) |=> $stable(s_q.crc));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_start && !byte_vld) |=> $stable(s_q.crc));
endmodule

// File: rtl/pmbus_pec_check.sv
module pmbus_pec_check #(
    parameter int                      W       = pec_pkg::PEC_W,
    parameter int                      CNT_W   = pec_pkg::PEC_CNT_W,
    parameter logic [pec_pkg::PEC_W-1:0] POLY  = pec_pkg::PEC_POLY,
    parameter logic [pec_pkg::PEC_W-1:0] INIT  = pec_pkg::PEC_INIT,
    parameter int                      MIN_HDR = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frm_start,
    input  logic         frm_rstart,
    input  logic         frm_stop,
    input  logic         byte_vld,
    input  logic         byte_dir,
    input  logic [7:0]   byte_data,
    output logic         cmd_accept,
    output logic         pec_err,
    output logic [7:0]   pec_byte
);
    logic [W-1:0] crc_base;
    logic [W-1:0] crc_next;
    logic [W-1:0] crc_cur;

    pec_crc_step #(.W(W), .POLY(POLY[W-1:0])) u_step (
        .crc_in  (crc_base),
        .data_in (byte_data),
        .crc_out (crc_next)
    );

    pec_frame_seq #(
        .W(W), .CNT_W(CNT_W), .INIT(INIT[W-1:0]), .MIN_HDR(MIN_HDR)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_start  (frm_start),
        .frm_rstart (frm_rstart),
        .frm_stop   (frm_stop),
        .byte_vld   (byte_vld),
        .byte_dir   (byte_dir),
        .crc_next   (crc_next),
        .crc_base   (crc_base),
        .crc_cur    (crc_cur),
        .accept     (cmd_accept),
        .err        (pec_err)
    );

    assign pec_byte = crc_cur;
endmodule

// File: tb/pmbus_pec_check_tb.sv
`timescale 1ns/1ps
module pmbus_pec_check_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_start = 1'b0, frm_rstart = 1'b0, frm_stop = 1'b0;
    logic       byte_vld = 1'b0, byte_dir = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       cmd_accept, pec_err;
    logic [7:0] pec_byte;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pmbus_pec_check u_dut (
        .clk(clk), .rst_n(rst_n),
        .frm_start(frm_start), .frm_rstart(frm_rstart), .frm_stop(frm_stop),
        .byte_vld(byte_vld), .byte_dir(byte_dir), .byte_data(byte_data),
        .cmd_accept(cmd_accept), .pec_err(pec_err), .pec_byte(pec_byte)
    );

    // Reference CRC: xor byte in, then eight shift/reduce rounds.
    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of markers at a negedge, return at the following negedge.
    task automatic step(input logic st, input logic rs, input logic sp,
                        input logic v, input logic dir, input logic [7:0] d);
        frm_start = st; frm_rstart = rs; frm_stop = sp;
        byte_vld = v; byte_dir = dir; byte_data = d;
        @(negedge clk);
        frm_start = 0; frm_rstart = 0; frm_stop = 0;
        byte_vld = 0; byte_dir = 0; byte_data = 8'h00;
    endtask

    task automatic stop_expect(input string tag, input logic acc, input logic er);
        step(0, 0, 1, 0, 0, 8'h00);
        chk({tag, " accept"}, {7'd0, cmd_accept}, {7'd0, acc});
        chk({tag, " err"}, {7'd0, pec_err}, {7'd0, er});
        @(negedge clk);
        chk("R8 pulse width", {6'd0, cmd_accept, pec_err}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        @(negedge clk);
        chk("R10 in reset", {6'd0, cmd_accept, pec_err}, 8'h00);
        chk("R10 pec in reset", pec_byte, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", {6'd0, cmd_accept, pec_err}, 8'h00);
        chk("R10 pec after reset", pec_byte, 8'h00);

        // Exhaustive over command byte: good code accepted, one-bit flip refused.
        for (int k = 0; k < 256; k++) begin
            logic [7:0] a, p;
            a = crc8(8'h00, 8'hB4);
            p = crc8(a, k[7:0]);
            step(1, 0, 0, 0, 0, 8'h00);
            chk("R2 start clears", pec_byte, 8'h00);
            step(0, 0, 0, 1, 0, 8'hB4);
            chk("R1 addr crc", pec_byte, a);
            step(0, 0, 0, 1, 0, k[7:0]);
            chk("R1 cmd crc", pec_byte, p);
            step(0, 0, 0, 1, 0, p);
            chk("R5 residue", pec_byte, 8'h00);
            stop_expect("R5 good code", 1'b1, 1'b0);
            step(1, 0, 0, 0, 0, 8'h00);
            step(0, 0, 0, 1, 0, 8'hB4);
            step(0, 0, 0, 1, 0, k[7:0]);
            step(0, 0, 0, 1, 0, p ^ (8'h01 << (k % 8)));
            stop_expect("R6 bad code", 1'b0, 1'b1);
        end

        // R7: missing code variants.
        step(1, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 8'hB4);
        stop_expect("R7 address only", 1'b0, 1'b1);
        step(1, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 8'hB4);
        step(0, 0, 0, 1, 0, crc8(8'h00, 8'hB4));
        chk("R7 short residue", pec_byte, 8'h00);
        stop_expect("R7 zero residue too early", 1'b0, 1'b1);
        c = crc8(crc8(8'h00, 8'hB4), 8'h21);
        step(1, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 8'hB4);
        step(0, 0, 0, 1, 0, 8'h21);
        step(0, 0, 0, 1, 0, c ^ 8'h5A);
        stop_expect("R7 data without code", 1'b0, 1'b1);
        step(1, 0, 0, 0, 0, 8'h00);
        stop_expect("R8 empty frame", 1'b0, 1'b0);

        // R3/R4: reads across a repeated START.
        for (int k = 0; k < 16; k++) begin
            logic [7:0] r, d1, d2;
            d1 = 8'(k * 37 + 5);
            d2 = 8'(k * 11 + 200);
            r = crc8(crc8(crc8(8'h00, 8'hB4), 8'h80 + k[7:0]), 8'hB5);
            step(1, 0, 0, 0, 0, 8'h00);
            step(0, 0, 0, 1, 0, 8'hB4);
            step(0, 0, 0, 1, 0, 8'h80 + k[7:0]);
            c = pec_byte;
            step(0, 1, 0, 0, 0, 8'h00);
            chk("R3 rstart keeps crc", pec_byte, c);
            step(0, 0, 0, 1, 0, 8'hB5);
            chk("R3 read crc spans write part", pec_byte, r);
            step(0, 0, 0, 1, 1, d1);
            r = crc8(r, d1);
            chk("R4 slave byte 1", pec_byte, r);
            step(0, 0, 0, 1, 1, d2);
            r = crc8(r, d2);
            chk("R4 code to append", pec_byte, r);
            step(0, 0, 0, 1, 1, r);
            chk("R4 after append", pec_byte, 8'h00);
            stop_expect("R8 read frame silent", 1'b0, 1'b0);
        end

        // R9: code byte together with STOP.
        c = crc8(crc8(8'h00, 8'hB4), 8'h03);
        step(1, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 8'hB4);
        step(0, 0, 0, 1, 0, 8'h03);
        step(0, 0, 1, 1, 0, c);
        chk("R9 byte with stop accept", {7'd0, cmd_accept}, 8'h01);
        chk("R9 byte with stop err", {7'd0, pec_err}, 8'h00);
        step(1, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 8'hB4);
        step(0, 0, 0, 1, 0, 8'h03);
        step(0, 0, 1, 1, 0, c ^ 8'h80);
        chk("R9 bad byte with stop err", {7'd0, pec_err}, 8'h01);

        // R9: first byte together with START, leftover CRC non-zero.
        step(1, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 8'h77);
        step(1, 0, 0, 1, 0, 8'hB4);
        chk("R9 byte with start", pec_byte, crc8(8'h00, 8'hB4));
        step(0, 0, 0, 1, 0, 8'h03);
        step(0, 0, 0, 1, 0, c);
        stop_expect("R9 frame after start+byte", 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule